// File: doc/BRIEF.md
# Power-State LED Blink Controller

This block drives two indicator lamps, one green and one yellow, from a small configuration register and a deep-sleep status input. While the deep-sleep input is high, one register bit picks which lamp is used and a second bit picks a steady lamp or a blinking one. While the input is low, both lamps stay dark.

The blink is slow and asymmetric. The lamp is lit for 0.59375 s and dark for 0.90625 s, which gives a 1.5 s period (about 0.67 Hz) and a duty of about 39.6 %. Timing comes from a single-cycle enable pulse at 32.768 kHz, so the lit phase is 19456 pulses long and the dark phase is 29696 pulses long. Both lengths are parameters.

Host software reaches the register through a plain byte write strobe and a combinational read-back. The register resets to its lamp-on-steady-green value on the standby power-on reset.

Top module: `led_power_blink`

## Requirements
- R1: During and after reset the register reads 0x03: bit 0 = 1 (green) and bit 1 = 1 (steady).
- R2: Read-back bits 7..2 are always 0, and write data on those bits has no effect.
- R3: While `slp_deep` is low, `led_green` and `led_yellow` are both 0.
- R4: While `slp_deep` is high, bit 0 = 1 routes the lamp to `led_green` and bit 0 = 0 routes it to `led_yellow`. The lamp that is not selected stays 0, so both outputs are never 1 together.
- R5: While `slp_deep` is high and bit 1 = 1, the selected lamp is lit continuously.
- R6: While `slp_deep` is high and bit 1 = 0, the selected lamp is lit for ON_TICKS enable pulses and then dark for OFF_TICKS pulses, repeating. The defaults are 19456 and 29696.
- R7: While `slp_deep` is low or bit 1 = 1, the blink timer is held at the start of its lit phase, so every blink sequence begins lit.
- R8: Changing bit 0 during a blink keeps the timer phase and position and only moves the lamp to the other output.
- R9: A write with `cfg_we` high updates the register at that clock edge. `cfg_rdata` shows the register contents combinationally.
- R10: The blink timer advances only on cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low standby power-on reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| slp_deep | input | 1 | High while the system is in its deepest sleep state |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back |
| led_green | output | 1 | Green lamp drive, active high |
| led_yellow | output | 1 | Yellow lamp drive, active high |

## Verification
The assertions assume that `tick_en` is a clean pulse sampled on `clk` and that `slp_deep` and the write port are synchronous to `clk`; no metastability handling is modelled. The bench drives every input just after the falling edge and holds it through the next rising edge, so each change lands at one known edge. It uses a tiny lit/dark configuration so that full blink periods, phase wraps and mid-phase colour switches all fit into a short sweep over every register value and both sleep levels.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned CFG_BITS = 2;

    // Bit 1 = steady, bit 0 = green select; the bit order matters for software.
    typedef struct packed {
        logic steady;
        logic green_sel;
    } led_cfg_t;

    localparam logic [REG_W-1:0] CFG_RESET = 8'h03;

endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
    import led_blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output led_cfg_t         cfg_o
);

    led_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = led_cfg_t'(wr_data[CFG_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= led_cfg_t'(CFG_RESET[CFG_BITS-1:0]);
        else        cfg_q <= cfg_d;
    end

    assign rd_data = {{(REG_W-CFG_BITS){1'b0}}, cfg_q};
    assign cfg_o   = cfg_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CFG_BITS-1:0] == $past(wr_data[CFG_BITS-1:0]))); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[REG_W-1:CFG_BITS] == '0)); // R2

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
    parameter int unsigned ON_TICKS  = 19456,
    parameter int unsigned OFF_TICKS = 29696
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic lit_o
);

    localparam int unsigned MAX_TICKS = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
    localparam int unsigned CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);

    typedef struct packed {
        logic             lit;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = st_q.lit ? ON_LAST : OFF_LAST;
        if (!run_i) begin
            st_d.lit = 1'b1;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == last) begin
                st_d.lit = ~st_q.lit;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lit: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign lit_o = st_q.lit;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lit ? (st_q.cnt <= ON_LAST) : (st_q.cnt <= OFF_LAST)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (lit_o && st_q.cnt == '0)); // R7
    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> ($stable(st_q.cnt) && $stable(lit_o))); // R10

endmodule

// File: rtl/led_route.sv
module led_route
    import led_blink_pkg::*;
(
    input  logic     slp_i,
    input  led_cfg_t cfg_i,
    input  logic     lit_i,
    output logic     green_o,
    output logic     yellow_o
);

    logic lamp;

    always_comb begin
        lamp     = slp_i & (cfg_i.steady | lit_i);
        green_o  = lamp &  cfg_i.green_sel;
        yellow_o = lamp & ~cfg_i.green_sel;
    end

endmodule

// File: rtl/led_power_blink.sv
module led_power_blink
    import led_blink_pkg::*;
#(
    parameter int unsigned ON_TICKS  = 19456,
    parameter int unsigned OFF_TICKS = 29696
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             slp_deep,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             led_green,
    output logic             led_yellow
);

    led_cfg_t cfg;
    logic     blink_run;
    logic     lit;

    led_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .cfg_o   (cfg)
    );

    assign blink_run = slp_deep & ~cfg.steady;

    led_blink_timer #(
        .ON_TICKS  (ON_TICKS),
        .OFF_TICKS (OFF_TICKS)
    ) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (blink_run),
        .tick_i (tick_en),
        .lit_o  (lit)
    );

    led_route i_route (
        .slp_i    (slp_deep),
        .cfg_i    (cfg),
        .lit_i    (lit),
        .green_o  (led_green),
        .yellow_o (led_yellow)
    );

    AST_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_green && led_yellow)); // R4
    AST_DARK_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_deep |-> (!led_green && !led_yellow)); // R3
    AST_STEADY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_deep && cfg_rdata[1]) |-> (led_green || led_yellow)); // R5

endmodule

// File: tb/test_led_power_blink.sv
`timescale 1ns/1ps
module test_led_power_blink;

    localparam int ON  = 3;
    localparam int OFF = 5;
    localparam int PER = ON + OFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       slp_deep = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       led_green, led_yellow;

    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [1:0] mreg = 2'b11;
    int         t = 0;
    string      tag = "";

    always #2.5 clk = ~clk;

    led_power_blink #(.ON_TICKS(ON), .OFF_TICKS(OFF)) i_led_power_blink (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .slp_deep(slp_deep),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .led_green(led_green), .led_yellow(led_yellow)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit s, bit tk, bit we, logic [7:0] d);
        bit    on, eg, ey;
        string lt;
        @(negedge clk);
        slp_deep = s; tick_en = tk; cfg_we = we; cfg_wdata = d;
        #1;
        on = mreg[1] ? 1'b1 : (t < ON);
        eg = s && mreg[0] && on;
        ey = s && !mreg[0] && on;
        if (tag != "")    lt = tag;
        else if (!s)      lt = "R3";
        else if (mreg[1]) lt = "R5";
        else              lt = "R6";
        chk(lt, led_green, eg);
        chk(lt, led_yellow, ey);
        chk("R4", led_green & led_yellow, 0);
        chk("R9", cfg_rdata, {6'b0, mreg});
        @(posedge clk);
        if (!(s && !mreg[1])) t = 0;
        else if (tk)          t = (t + 1) % PER;
        if (we) mreg = d[1:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", cfg_rdata, 8'h03);
        chk("R1", led_green | led_yellow, 0);
        rst_n = 1'b1;
        chk("R1", cfg_rdata, 8'h03);

        // sweep every register value at both sleep levels
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                step(s[0], 1'b0, 1'b1, 8'(m));
                for (int i = 0; i < 40; i++) step(s[0], (i % 3) != 2, 1'b0, 8'h00);
            end
        end

        // reserved bits
        tag = "R2";
        step(1'b0, 1'b0, 1'b1, 8'hFC);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R2", cfg_rdata, 8'h00);
        step(1'b0, 1'b0, 1'b1, 8'hFF);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R2", cfg_rdata, 8'h03);

        // colour change mid-blink keeps the phase
        tag = "R8";
        step(1'b1, 1'b0, 1'b1, 8'h01);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b1, 8'h01);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 8'h00);

        // restart: sleep dropped mid dark phase, then steady and back
        tag = "R7";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b1, 8'h03);
        step(1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 8'h00);

        // no tick, no progress
        tag = "R10";
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 12; i++) step(1'b1, i == 5, 1'b0, 8'h00);
        tag = "";

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule